// File: doc/BRIEF.md
# Per-Scanline Event Sequencer

This block walks a fixed circle of six timed events inside every scanline of a video timing chain. An external horizontal master-cycle count is compared against the compare position of the current event. When the count reaches that position, the block raises a one-cycle strobe for the event and loads the compare position of the event that follows. Three of the strobes are qualified by the line number, the visible height and the DMA channel mask, so downstream engines only see the pulses that matter to them. The refresh event also holds a stall request towards the processor for a fixed number of cycles.

The six positions come from parameters. The refresh position is the exception. On the later chip revision it moves by one dot from line to line, and it stays put on one particular line of an odd, non-interlaced field. The block carries no data stream, so every pin is a plain control or status level. There is no valid/ready handshake and no back-pressure.

Top module: `scanline_event_seq`

## Requirements
- R1: After reset `ev_idx` is 0 and all strobes, `stall` and `render_line` are 0. `ev_idx` encodes the current event as 0 hblank start, 1 line DMA start, 2 line end, 3 line DMA init, 4 render, 5 refresh. It advances by one, wrapping from 5 to 0, each time the current event fires.
- R2: An event fires at a clock edge where `hcount` is greater than or equal to its compare position, which also covers counts that jump by more than one. The event's strobe is high for exactly the following cycle, and the next event's position is loaded. After reset the compare position is the hblank position.
- R3: `ev_dma_start` pulses only when the line DMA start event fires, at least one bit of `dma_active` is set, and `vline` <= `vis_height`.
- R4: `ev_dma_init` pulses only when the line DMA init event fires on line 0.
- R5: `ev_render` pulses only when the render event fires with 1 <= `vline` <= `vis_height`. At the same time `render_line` takes `vline`-1 and holds it until the next render pulse.
- R6: When the refresh event fires, `stall` is high for exactly REFRESH_CYCLES consecutive cycles, starting with the cycle of `ev_refresh`.
- R7: With `rev2`=1 the refresh position alternates between REF_POS_EARLY and REF_POS_LATE. The phase toggles each time the line end fires, and it is EARLY after reset. The render event loads the refresh position that is current at that moment.
- R8: With `rev2`=1 the phase does not toggle when the line end fires with `vline`==SPECIAL_LINE, `odd_field`=1 and `interlace`=0.
- R9: With `rev2`=0 the refresh position is always REF_POS_R1 and the phase does not toggle.
- R10: After the line end fires, no event fires until an edge has seen `hcount` < LINE_LEN. Comparison resumes at the edge after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcount | input | HW | Horizontal master-cycle count |
| vline | input | VW | Current line number |
| vis_height | input | VW | Last visible line |
| dma_active | input | NCH | Per-channel line DMA enable mask |
| rev2 | input | 1 | Selects the alternating refresh position |
| odd_field | input | 1 | Current field is odd |
| interlace | input | 1 | Interlaced output mode |
| ev_idx | output | 3 | Current event (encoding in R1) |
| ev_hblank | output | 1 | Hblank start strobe |
| ev_dma_start | output | 1 | Qualified line DMA start strobe |
| ev_line_end | output | 1 | Line end strobe |
| ev_dma_init | output | 1 | Qualified line DMA init strobe |
| ev_render | output | 1 | Qualified render strobe |
| render_line | output | VW | Line index for the renderer |
| ev_refresh | output | 1 | RAM refresh strobe |
| stall | output | 1 | Processor stall request during refresh |

## Verification
The bench builds the block with HW=8, VW=4, NCH=4, a 100-cycle line, positions scaled down into it, SPECIAL_LINE=6 and REFRESH_CYCLES=5. With a ten-line frame and a visible height of 4 or 7, every line gate, the line-0 DMA init and the special suppression line come up every frame. The count is stepped by three at times and runs a little past the line length before it wraps, so the jump rule and the wait-for-wrap rule are both exercised. Eight frames cycle through the revision, interlace, field parity and DMA-mask combinations, and that reaches both refresh positions and the frozen-phase case.

// File: rtl/sls_pkg.sv
package sls_pkg;
  typedef enum logic [2:0] {
    EV_HBLANK    = 3'd0,
    EV_DMA_START = 3'd1,
    EV_LINE_END  = 3'd2,
    EV_DMA_INIT  = 3'd3,
    EV_RENDER    = 3'd4,
    EV_REFRESH   = 3'd5
  } ev_e;

  localparam int NUM_EV = 6;

  function automatic ev_e next_ev(input ev_e cur);
    ev_e n;
    case (cur)
      EV_HBLANK:    n = EV_DMA_START;
      EV_DMA_START: n = EV_LINE_END;
      EV_LINE_END:  n = EV_DMA_INIT;
      EV_DMA_INIT:  n = EV_RENDER;
      EV_RENDER:    n = EV_REFRESH;
      default:      n = EV_HBLANK;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/sls_refresh_pos.sv
module sls_refresh_pos #(
  parameter int HW            = 11,
  parameter int VW            = 9,
  parameter int SPECIAL_LINE  = 240,
  parameter int REF_POS_R1    = 538,
  parameter int REF_POS_EARLY = 534,
  parameter int REF_POS_LATE  = 538
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end_hit,
  input  logic [VW-1:0] vline,
  input  logic          rev2,
  input  logic          odd_field,
  input  logic          interlace,
  output logic [HW-1:0] ref_pos
);
  localparam logic [VW-1:0] SPC   = VW'(SPECIAL_LINE);
  localparam logic [HW-1:0] P_R1  = HW'(REF_POS_R1);
  localparam logic [HW-1:0] P_ERL = HW'(REF_POS_EARLY);
  localparam logic [HW-1:0] P_LAT = HW'(REF_POS_LATE);

  logic late_q;
  logic freeze;

  assign freeze = (vline == SPC) && odd_field && !interlace;

  always_ff @(posedge clk) begin
    if (!rst_n)
      late_q <= 1'b0;
    else if (line_end_hit && rev2 && !freeze)
      late_q <= !late_q;
  end

  always_comb begin
    if (!rev2)       ref_pos = P_R1;
    else if (late_q) ref_pos = P_LAT;
    else             ref_pos = P_ERL;
  end
endmodule

// File: rtl/sls_ring.sv
module sls_ring
  import sls_pkg::*;
#(
  parameter int HW            = 11,
  parameter int POS_HBLANK    = 1096,
  parameter int POS_DMA_START = 1106,
  parameter int LINE_LEN      = 1364,
  parameter int POS_DMA_INIT  = 20,
  parameter int POS_RENDER    = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcount,
  input  logic [HW-1:0] ref_pos,
  output ev_e           cur_ev,
  output logic          fire
);
  localparam logic [HW-1:0] P_HB = HW'(POS_HBLANK);
  localparam logic [HW-1:0] P_DS = HW'(POS_DMA_START);
  localparam logic [HW-1:0] P_LE = HW'(LINE_LEN);
  localparam logic [HW-1:0] P_DI = HW'(POS_DMA_INIT);
  localparam logic [HW-1:0] P_RN = HW'(POS_RENDER);

  ev_e           ev_q;
  logic [HW-1:0] cmp_q;
  logic          wrap_wait_q;
  logic [HW-1:0] next_cmp;

  assign fire   = !wrap_wait_q && (hcount >= cmp_q);
  assign cur_ev = ev_q;

  always_comb begin
    case (ev_q)
      EV_HBLANK:    next_cmp = P_DS;
      EV_DMA_START: next_cmp = P_LE;
      EV_LINE_END:  next_cmp = P_DI;
      EV_DMA_INIT:  next_cmp = P_RN;
      EV_RENDER:    next_cmp = ref_pos;
      default:      next_cmp = P_HB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q        <= EV_HBLANK;
      cmp_q       <= P_HB;
      wrap_wait_q <= 1'b0;
    end else if (wrap_wait_q) begin
      if (hcount < P_LE)
        wrap_wait_q <= 1'b0;
    end else if (fire) begin
      ev_q  <= next_ev(ev_q);
      cmp_q <= next_cmp;
      if (ev_q == EV_LINE_END)
        wrap_wait_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sls_strobes.sv
module sls_strobes
  import sls_pkg::*;
#(
  parameter int VW  = 9,
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  ev_e            cur_ev,
  input  logic [VW-1:0]  vline,
  input  logic [VW-1:0]  vis_height,
  input  logic [NCH-1:0] dma_active,
  output logic [NUM_EV-1:0] strobe,
  output logic [VW-1:0]  render_line
);
  localparam logic [VW-1:0] FIRST_VIS = VW'(1);

  logic [NUM_EV-1:0] hit;
  logic [NUM_EV-1:0] qual;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_hit
    assign hit[g] = fire && (cur_ev == ev_e'(g));
  end

  always_comb begin
    qual = '1;
    qual[EV_DMA_START] = (|dma_active) && (vline <= vis_height);
    qual[EV_DMA_INIT]  = (vline == '0);
    qual[EV_RENDER]    = (vline >= FIRST_VIS) && (vline <= vis_height);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe      <= '0;
      render_line <= '0;
    end else begin
      strobe <= hit & qual;
      if (hit[EV_RENDER] && qual[EV_RENDER])
        render_line <= vline - FIRST_VIS;
    end
  end
endmodule

// File: rtl/sls_stall.sv
module sls_stall #(
  parameter int REFRESH_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic stall
);
  localparam int SCW = $clog2(REFRESH_CYCLES + 1);
  localparam logic [SCW-1:0] LOAD = SCW'(REFRESH_CYCLES);

  logic [SCW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (start)
      cnt_q <= LOAD;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign stall = (cnt_q != '0);
endmodule

// File: rtl/scanline_event_seq.sv
module scanline_event_seq
  import sls_pkg::*;
#(
  parameter int HW             = 11,
  parameter int VW             = 9,
  parameter int NCH            = 8,
  parameter int POS_HBLANK     = 1096,
  parameter int POS_DMA_START  = 1106,
  parameter int LINE_LEN       = 1364,
  parameter int POS_DMA_INIT   = 20,
  parameter int POS_RENDER     = 128,
  parameter int REF_POS_R1     = 538,
  parameter int REF_POS_EARLY  = 534,
  parameter int REF_POS_LATE   = 538,
  parameter int SPECIAL_LINE   = 240,
  parameter int REFRESH_CYCLES = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HW-1:0]  hcount,
  input  logic [VW-1:0]  vline,
  input  logic [VW-1:0]  vis_height,
  input  logic [NCH-1:0] dma_active,
  input  logic           rev2,
  input  logic           odd_field,
  input  logic           interlace,
  output logic [2:0]     ev_idx,
  output logic           ev_hblank,
  output logic           ev_dma_start,
  output logic           ev_line_end,
  output logic           ev_dma_init,
  output logic           ev_render,
  output logic [VW-1:0]  render_line,
  output logic           ev_refresh,
  output logic           stall
);
  ev_e               cur_ev;
  logic              fire;
  logic [HW-1:0]     ref_pos;
  logic [NUM_EV-1:0] strobe;
  logic              line_end_hit;

  assign line_end_hit = fire && (cur_ev == EV_LINE_END);

  sls_ring #(
    .HW(HW), .POS_HBLANK(POS_HBLANK), .POS_DMA_START(POS_DMA_START),
    .LINE_LEN(LINE_LEN), .POS_DMA_INIT(POS_DMA_INIT), .POS_RENDER(POS_RENDER)
  ) u_ring (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .ref_pos(ref_pos),
    .cur_ev(cur_ev), .fire(fire)
  );

  sls_refresh_pos #(
    .HW(HW), .VW(VW), .SPECIAL_LINE(SPECIAL_LINE), .REF_POS_R1(REF_POS_R1),
    .REF_POS_EARLY(REF_POS_EARLY), .REF_POS_LATE(REF_POS_LATE)
  ) u_refpos (
    .clk(clk), .rst_n(rst_n), .line_end_hit(line_end_hit), .vline(vline),
    .rev2(rev2), .odd_field(odd_field), .interlace(interlace), .ref_pos(ref_pos)
  );

  sls_strobes #(.VW(VW), .NCH(NCH)) u_strb (
    .clk(clk), .rst_n(rst_n), .fire(fire), .cur_ev(cur_ev), .vline(vline),
    .vis_height(vis_height), .dma_active(dma_active), .strobe(strobe),
    .render_line(render_line)
  );

  sls_stall #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_stall (
    .clk(clk), .rst_n(rst_n), .start(fire && (cur_ev == EV_REFRESH)),
    .stall(stall)
  );

  assign ev_idx       = cur_ev;
  assign ev_hblank    = strobe[EV_HBLANK];
  assign ev_dma_start = strobe[EV_DMA_START];
  assign ev_line_end  = strobe[EV_LINE_END];
  assign ev_dma_init  = strobe[EV_DMA_INIT];
  assign ev_render    = strobe[EV_RENDER];
  assign ev_refresh   = strobe[EV_REFRESH];
endmodule

// File: rtl/sls_checker.sv
module sls_checker #(
  parameter int VW  = 9,
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [VW-1:0]  vline,
  input logic [VW-1:0]  vis_height,
  input logic [NCH-1:0] dma_active,
  input logic [2:0]     ev_idx,
  input logic           ev_hblank,
  input logic           ev_dma_start,
  input logic           ev_line_end,
  input logic           ev_dma_init,
  input logic           ev_render,
  input logic [VW-1:0]  render_line,
  input logic           ev_refresh,
  input logic           stall
);
  AST_RING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ev_idx) |-> (ev_idx == (($past(ev_idx) == 3'd5) ? 3'd0 : $past(ev_idx) + 3'd1))); // R1
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_hblank, ev_dma_start, ev_line_end, ev_dma_init, ev_render, ev_refresh})); // R2
  AST_DMA_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dma_start |-> ($past(|dma_active) && ($past(vline) <= $past(vis_height)))); // R3
  AST_INIT_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dma_init |-> ($past(vline) == '0)); // R4
  AST_RENDER_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    ev_render |-> (render_line == $past(vline) - 1'b1)); // R5
  AST_STALL_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refresh |-> stall); // R6
  AST_LINE_END_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_line_end |=> !ev_line_end); // R10
endmodule

bind scanline_event_seq sls_checker #(.VW(VW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .vline(vline), .vis_height(vis_height),
  .dma_active(dma_active), .ev_idx(ev_idx), .ev_hblank(ev_hblank),
  .ev_dma_start(ev_dma_start), .ev_line_end(ev_line_end),
  .ev_dma_init(ev_dma_init), .ev_render(ev_render),
  .render_line(render_line), .ev_refresh(ev_refresh), .stall(stall)
);

// File: tb/sim_scanline_event_seq.sv
module sim_scanline_event_seq;
  localparam int PERIOD = 10;
  localparam int HW = 8, VW = 4, NCH = 4;
  localparam int P_HB = 70, P_DS = 75, L_LEN = 100, P_DI = 4, P_RN = 10;
  localparam int R1P = 40, RE = 38, RL = 40, SPC = 6, RCY = 5, NLINES = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW-1:0] hcount = '0;
  logic [VW-1:0] vline = '0, vis_height = 4'd4;
  logic [NCH-1:0] dma_active = '0;
  logic rev2 = 1'b0, odd_field = 1'b0, interlace = 1'b0;
  logic [2:0] ev_idx;
  logic ev_hblank, ev_dma_start, ev_line_end, ev_dma_init, ev_render, ev_refresh, stall;
  logic [VW-1:0] render_line;

  int checks = 0, errors = 0;
  bit done = 0;

  scanline_event_seq #(
    .HW(HW), .VW(VW), .NCH(NCH), .POS_HBLANK(P_HB), .POS_DMA_START(P_DS),
    .LINE_LEN(L_LEN), .POS_DMA_INIT(P_DI), .POS_RENDER(P_RN), .REF_POS_R1(R1P),
    .REF_POS_EARLY(RE), .REF_POS_LATE(RL), .SPECIAL_LINE(SPC), .REFRESH_CYCLES(RCY)
  ) u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_ev, m_cmp, m_stall, m_rl;
  bit m_ww, m_late, m_frz_line;
  bit e_hb, e_ds, e_le, e_di, e_rn, e_rf;

  always @(posedge clk) begin
    bit f;
    if (!rst_n) begin
      m_ev = 0; m_cmp = P_HB; m_ww = 0; m_late = 0; m_stall = 0; m_rl = 0;
      {e_hb, e_ds, e_le, e_di, e_rn, e_rf} = '0;
    end else begin
      {e_hb, e_ds, e_le, e_di, e_rn, e_rf} = '0;
      f = !m_ww && (int'(hcount) >= m_cmp);
      if (m_ww && int'(hcount) < L_LEN) m_ww = 0;
      if (m_stall > 0) m_stall--;
      if (f) begin
        case (m_ev)
          0: begin e_hb = 1; m_cmp = P_DS; end
          1: begin e_ds = (dma_active != 0) && (vline <= vis_height); m_cmp = L_LEN; end
          2: begin
               e_le = 1; m_cmp = P_DI; m_ww = 1;
               m_frz_line = (int'(vline) == SPC) && odd_field && !interlace;
               if (rev2 && !m_frz_line) m_late = !m_late;
             end
          3: begin e_di = (vline == 0); m_cmp = P_RN; end
          4: begin
               if (vline >= 1 && vline <= vis_height) begin e_rn = 1; m_rl = int'(vline) - 1; end
               m_cmp = rev2 ? (m_late ? RL : RE) : R1P;
             end
          default: begin e_rf = 1; m_stall = RCY; m_cmp = P_HB; end
        endcase
        m_ev = (m_ev + 1) % 6;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(m_ww ? "R10 ev_idx" : "R1 ev_idx", ev_idx, m_ev);
    chk("R2 ev_hblank", ev_hblank, e_hb);
    chk("R2 ev_line_end", ev_line_end, e_le);
    chk("R3 ev_dma_start", ev_dma_start, e_ds);
    chk("R4 ev_dma_init", ev_dma_init, e_di);
    chk("R5 ev_render", ev_render, e_rn);
    chk("R5 render_line", render_line, m_rl);
    chk(!rev2 ? "R9 ev_refresh" : (m_frz_line ? "R8 ev_refresh" : "R7 ev_refresh"),
        ev_refresh, e_rf);
    chk("R6 stall", stall, m_stall != 0);
  endtask

  initial begin
    int step;
    repeat (3) @(negedge clk);
    compare_all();                               // R1 reset state
    rst_n = 1'b1;
    for (int fr = 0; fr < 8; fr++) begin
      rev2       = (fr >= 2) && (fr != 6);
      interlace  = (fr == 5);
      dma_active = fr[0] ? 4'b0100 : 4'b0000;
      vis_height = fr[1] ? 4'd7 : 4'd4;
      for (int ln = 0; ln < NLINES; ln++) begin
        vline = VW'(ln);
        hcount = '0;
        while (int'(hcount) < L_LEN + 2) begin
          @(negedge clk);
          compare_all();
          step = (int'(hcount) % 7 == 3) ? 3 : 1;   // R2 jumps
          hcount = hcount + HW'(step);
        end
        @(negedge clk);
        compare_all();
      end
      odd_field = !odd_field;
    end
    repeat (RCY + 2) begin @(negedge clk); compare_all(); end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule